// File: doc/BRIEF.md
# JTAG Scan Command Sequencer

This block drives a JTAG chain in hardware from three high-level commands: shift a vector into the instruction register, shift a vector through a data register, and hold the TAP in Run-Test/Idle for a programmed number of TCK pulses. A fourth command walks every TAP on the chain into Test-Logic-Reset and then parks it in Run-Test/Idle. The block builds the TCK, TMS and TDI waveforms itself. TCK is derived from the system clock by a programmable half-period divider. TMS and TDI change only when TCK falls, and TDO is sampled when TCK rises.

A command is accepted when the command strobe is high and the block is not busy. The opcode, scan length and wait count are taken from the command inputs in that cycle, and the outgoing vector, expected vector and care mask are taken from their ports. On a data scan, every TDO bit is stored into the capture vector in shift order. The captured bits are then compared with the expected vector wherever the care mask is set. When the TAP is back in Run-Test/Idle, the block drops busy, pulses done for one cycle and updates a sticky mismatch flag. Every scan command ends in Run-Test/Idle.

Top module: `jtag_cmd_seq`

## Requirements
- R1: After reset: TCK is 0, TMS is 1, busy, done and mismatch are 0, and the capture vector is all zero.
- R2: Each TCK high phase and each low phase within a pulse lasts max(tck_half,1) system cycles (a tck_half of 0 acts as 1). TMS and TDI never change while TCK is high.
- R3: Opcode 2'b00 (reset) produces exactly six TCK pulses, with TMS sampled as 1,1,1,1,1,0 at the rising edges.
- R4: Opcode 2'b01 (IR scan) of length N produces TMS 1,1,0,0, then N shift pulses with TMS 0 except 1 on the last, then 1,0. During the shift pulses TDI carries scan_out[0] through scan_out[N-1] in that order. TDO is ignored, so the capture vector keeps its previous value.
- R5: Opcode 2'b10 (DR scan) of length N produces TMS 1,0,0, then N shift pulses (TMS 1 only on the last), then 1,0. TDI carries scan_out bits least significant first.
- R6: During a DR scan, the TDO value at the rising TCK edge of shift pulse i (counting from 0) lands in scan_in[i]. All capture bits are cleared when a DR scan is accepted, so bits at positions N and above read 0.
- R7: When a DR scan completes, mismatch is set if some bit i < N has scan_care[i]=1 and scan_in[i] differs from scan_expect[i]. Bits with a care value of 0, and bits at N or above, never set it.
- R8: mismatch only changes together with done, and it holds its value until the next command is accepted, which clears it.
- R9: Opcode 2'b11 (wait) with count W produces W TCK pulses with TMS 0. A count of 0 produces no pulse and still completes.
- R10: busy is high from the cycle after acceptance until completion. done is a single-cycle pulse in the cycle busy falls. A command strobed while busy is ignored: it causes no extra pulse, no extra done and no change to the running sequence.
- R11: Scan lengths 1 and MAX_LEN (1024) both follow R5 to R7 exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when not busy |
| cmd_op | input | 2 | 00 reset, 01 IR scan, 10 DR scan, 11 wait |
| cmd_len | input | LEN_W (11) | Scan length in bits, 1..MAX_LEN |
| cmd_wait | input | WAIT_W (16) | Number of idle TCK pulses for the wait command |
| tck_half | input | DIV_W (8) | TCK half period in system cycles (0 acts as 1) |
| scan_out | input | MAX_LEN | Vector shifted out on TDI, bit 0 first |
| scan_expect | input | MAX_LEN | Expected TDO vector for DR scans |
| scan_care | input | MAX_LEN | Compare mask, 1 = bit is checked |
| jtag_tdo | input | 1 | Serial data returned by the chain |
| jtag_tck | output | 1 | Test clock |
| jtag_tms | output | 1 | Test mode select |
| jtag_tdi | output | 1 | Serial data into the chain |
| scan_in | output | MAX_LEN | Captured TDO vector of the last DR scan |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| mismatch | output | 1 | Sticky masked compare failure |

## Verification
The bench targets the final shift bit. A design that raised TMS one pulse early or late would shift the wrong number of bits and land in the wrong TAP state, and the recorded TMS sequence exposes that. It also targets the compare boundaries: a differing bit under a zero care bit, a differing expected bit beyond the scan length, and a difference only in bit 1023 of a full-length scan. A compare that ignored the mask or the length would raise mismatch falsely, and one that missed the last bit would stay quiet. Further cases are a zero wait count (a wrong design hangs or emits a stray pulse), a tck_half of 0 (a wrong design stalls or produces zero-length phases), and a reset command strobed mid-scan (a wrong design breaks the running sequence or reports done twice).

// File: rtl/jseq_pkg.sv
// Shared types for the JTAG scan command sequencer.
// Assumes: opcode values are fixed by the command interface.
package jseq_pkg;
    typedef enum logic [1:0] {
        OP_RESET  = 2'b00,
        OP_IRSCAN = 2'b01,
        OP_DRSCAN = 2'b10,
        OP_WAIT   = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HEAD,
        PH_SHIFT,
        PH_TAIL,
        PH_PAUSE,
        PH_DRAIN
    } phase_e;
endpackage

// File: rtl/jseq_tck_gen.sv
// TCK pulse engine: runs one TCK pulse per accepted request.
// A pulse is a low phase then a high phase, each max(half_i,1) cycles long.
// TMS/TDI are loaded when the pulse starts (TCK falls or is already low).
// sample_o marks the cycle whose closing edge raises TCK, where TDO is taken.
// Assumes: half_i is held stable while pulses run.
module jseq_tck_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_i,
    input  logic             req_i,
    input  logic             req_tms_i,
    input  logic             req_tdi_i,
    input  logic             req_cap_i,
    output logic             take_o,
    output logic             sample_o,
    output logic             sample_cap_o,
    output logic             active_o,
    output logic             tck_o,
    output logic             tms_o,
    output logic             tdi_o
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic             active_q, hi_q, tck_q, tms_q, tdi_q, cap_q;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] half;
    logic             ready;

    // effective half period, zero treated as one
    assign half  = (half_i == '0) ? ONE : half_i;
    // a new pulse may start when idle or on the last high cycle
    assign ready = !active_q || (hi_q && cnt_q == ONE);

    assign take_o       = req_i && ready;
    assign sample_o     = active_q && !hi_q && cnt_q == ONE;
    assign sample_cap_o = sample_o && cap_q;
    assign active_o     = active_q;
    assign tck_o        = tck_q;
    assign tms_o        = tms_q;
    assign tdi_o        = tdi_q;

    // phase counter and pin registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            hi_q     <= 1'b0;
            tck_q    <= 1'b0;
            tms_q    <= 1'b1;
            tdi_q    <= 1'b0;
            cap_q    <= 1'b0;
            cnt_q    <= '0;
        end else if (take_o) begin
            active_q <= 1'b1;
            hi_q     <= 1'b0;
            tck_q    <= 1'b0;
            tms_q    <= req_tms_i;
            tdi_q    <= req_tdi_i;
            cap_q    <= req_cap_i;
            cnt_q    <= half;
        end else if (active_q) begin
            if (cnt_q == ONE) begin
                if (!hi_q) begin
                    hi_q  <= 1'b1;
                    tck_q <= 1'b1;
                    cnt_q <= half;
                end else begin
                    active_q <= 1'b0;
                    hi_q     <= 1'b0;
                    tck_q    <= 1'b0;
                end
            end else begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

    // R2
    pins_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tck_q && $past(tck_q)) |-> ($stable(tms_q) && $stable(tdi_q)));

    // R2
    rise_follows_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tck_q) |-> $past(sample_o));
endmodule

// File: rtl/jseq_scanbuf.sv
// Scan data path: outgoing shift register, expected/care shift registers,
// indexed capture vector and a sticky masked-compare error bit.
// Assumes: load_i never coincides with shift_i or cap_i.
module jseq_scanbuf #(
    parameter int MAX_LEN = 1024,
    parameter int IDX_W   = $clog2(MAX_LEN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               clr_cap_i,
    input  logic [MAX_LEN-1:0] data_i,
    input  logic [MAX_LEN-1:0] exp_i,
    input  logic [MAX_LEN-1:0] care_i,
    input  logic               shift_i,
    input  logic               cap_i,
    input  logic               tdo_i,
    output logic               out_bit_o,
    output logic [MAX_LEN-1:0] cap_o,
    output logic               err_o
);
    logic [MAX_LEN-1:0] out_q, exp_q, care_q, cap_q;
    logic [IDX_W-1:0]   idx_q;
    logic               err_q;

    assign out_bit_o = out_q[0];
    assign cap_o     = cap_q;
    assign err_o     = err_q;

    // outgoing vector, consumed one bit per shift pulse
    always_ff @(posedge clk) begin
        if (!rst_n)        out_q <= '0;
        else if (load_i)   out_q <= data_i;
        else if (shift_i)  out_q <= out_q >> 1;
    end

    // expected and care vectors, consumed one bit per captured TDO bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q  <= '0;
            care_q <= '0;
        end else if (load_i) begin
            exp_q  <= exp_i;
            care_q <= care_i;
        end else if (cap_i) begin
            exp_q  <= exp_q >> 1;
            care_q <= care_q >> 1;
        end
    end

    // capture vector written in shift order
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
            idx_q <= '0;
        end else if (load_i && clr_cap_i) begin
            cap_q <= '0;
            idx_q <= '0;
        end else if (cap_i) begin
            cap_q[idx_q] <= tdo_i;
            idx_q        <= idx_q + IDX_W'(1);
        end
    end

    // compare each bit as it arrives, sticky within a command
    always_ff @(posedge clk) begin
        if (!rst_n)                                   err_q <= 1'b0;
        else if (load_i)                              err_q <= 1'b0;
        else if (cap_i && care_q[0] && (tdo_i ^ exp_q[0])) err_q <= 1'b1;
    end

    // R6
    capture_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i |=> (cap_q[$past(idx_q)] == $past(tdo_i)));

    // R7
    err_needs_cared_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(cap_i && care_q[0]));
endmodule

// File: rtl/jseq_ctrl.sv
// Command sequencer: accepts a command when idle and issues the TMS pulse
// list for it (header leg, shift bits, exit/update/idle tail, or idle wait),
// then waits for the pulse engine to finish before reporting done.
// Assumes: the engine takes one request per take_i and reports active_i.
module jseq_ctrl
    import jseq_pkg::*;
#(
    parameter int LEN_W  = 11,
    parameter int WAIT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  logic [1:0]        cmd_op_i,
    input  logic [LEN_W-1:0]  cmd_len_i,
    input  logic [WAIT_W-1:0] cmd_wait_i,
    input  logic              take_i,
    input  logic              active_i,
    input  logic              err_i,
    output logic              accept_o,
    output logic              accept_dr_o,
    output logic              req_o,
    output logic              req_tms_o,
    output logic              req_shift_o,
    output logic              req_cap_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              mismatch_o
);
    localparam int CNT_W = (LEN_W > WAIT_W) ? LEN_W : WAIT_W;
    localparam logic [CNT_W-1:0] C1 = CNT_W'(1);

    phase_e             ph_q;
    op_e                op_q;
    logic [CNT_W-1:0]   idx_q, len_last, wait_last, head_last;
    logic [LEN_W-1:0]   len_q;
    logic [WAIT_W-1:0]  wait_q;
    logic               busy_q, done_q, mis_q;

    // number of header pulses for each leg
    function automatic logic [CNT_W-1:0] head_len(input op_e o);
        case (o)
            OP_RESET:  head_len = CNT_W'(6);
            OP_IRSCAN: head_len = CNT_W'(4);
            default:   head_len = CNT_W'(3);
        endcase
    endfunction

    assign len_last    = CNT_W'(len_q) - C1;
    assign wait_last   = CNT_W'(wait_q) - C1;
    assign head_last   = head_len(op_q) - C1;
    assign accept_o    = cmd_valid_i && !busy_q;
    assign accept_dr_o = accept_o && (op_e'(cmd_op_i) == OP_DRSCAN);
    assign busy_o      = busy_q;
    assign done_o      = done_q;
    assign mismatch_o  = mis_q;

    // TMS value and pulse type for the current step
    always_comb begin
        req_o       = 1'b0;
        req_tms_o   = 1'b0;
        req_shift_o = 1'b0;
        req_cap_o   = 1'b0;
        case (ph_q)
            PH_HEAD: begin
                req_o = 1'b1;
                case (op_q)
                    OP_RESET:  req_tms_o = (idx_q < CNT_W'(5));
                    OP_IRSCAN: req_tms_o = (idx_q < CNT_W'(2));
                    default:   req_tms_o = (idx_q == '0);
                endcase
            end
            PH_SHIFT: begin
                req_o       = 1'b1;
                req_shift_o = 1'b1;
                req_tms_o   = (idx_q == len_last);
                req_cap_o   = (op_q == OP_DRSCAN);
            end
            PH_TAIL: begin
                req_o     = 1'b1;
                req_tms_o = (idx_q == '0);
            end
            PH_PAUSE: req_o = 1'b1;
            default: ;
        endcase
    end

    // command acceptance and step sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_IDLE;
            op_q   <= OP_RESET;
            idx_q  <= '0;
            len_q  <= '0;
            wait_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            mis_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept_o) begin
                busy_q <= 1'b1;
                mis_q  <= 1'b0;
                op_q   <= op_e'(cmd_op_i);
                len_q  <= cmd_len_i;
                wait_q <= cmd_wait_i;
                idx_q  <= '0;
                if (op_e'(cmd_op_i) == OP_WAIT)
                    ph_q <= (cmd_wait_i == '0) ? PH_DRAIN : PH_PAUSE;
                else
                    ph_q <= PH_HEAD;
            end else begin
                case (ph_q)
                    PH_HEAD: if (take_i) begin
                        if (idx_q == head_last) begin
                            idx_q <= '0;
                            ph_q  <= (op_q == OP_RESET) ? PH_DRAIN : PH_SHIFT;
                        end else idx_q <= idx_q + C1;
                    end
                    PH_SHIFT: if (take_i) begin
                        if (idx_q == len_last) begin
                            idx_q <= '0;
                            ph_q  <= PH_TAIL;
                        end else idx_q <= idx_q + C1;
                    end
                    PH_TAIL: if (take_i) begin
                        if (idx_q == C1) ph_q <= PH_DRAIN;
                        else             idx_q <= idx_q + C1;
                    end
                    PH_PAUSE: if (take_i) begin
                        if (idx_q == wait_last) ph_q <= PH_DRAIN;
                        else                    idx_q <= idx_q + C1;
                    end
                    PH_DRAIN: if (!active_i) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                        mis_q  <= err_i;
                        ph_q   <= PH_IDLE;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R10
    busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> done_q);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R10
    busy_rise_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(cmd_valid_i));

    // R8
    mismatch_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mis_q) |-> done_q);
endmodule

// File: rtl/jtag_cmd_seq.sv
// JTAG scan command sequencer top: ties the command sequencer, the TCK
// pulse engine and the scan data path together.
// Assumes: scan_out/scan_expect/scan_care are valid in the accept cycle.
module jtag_cmd_seq #(
    parameter int MAX_LEN = 1024,
    parameter int DIV_W   = 8,
    parameter int WAIT_W  = 16,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [LEN_W-1:0]   cmd_len,
    input  logic [WAIT_W-1:0]  cmd_wait,
    input  logic [DIV_W-1:0]   tck_half,
    input  logic [MAX_LEN-1:0] scan_out,
    input  logic [MAX_LEN-1:0] scan_expect,
    input  logic [MAX_LEN-1:0] scan_care,
    input  logic               jtag_tdo,
    output logic               jtag_tck,
    output logic               jtag_tms,
    output logic               jtag_tdi,
    output logic [MAX_LEN-1:0] scan_in,
    output logic               busy,
    output logic               done,
    output logic               mismatch
);
    logic accept, accept_dr, req, req_tms, req_shift, req_cap;
    logic take, sample, sample_cap, active, out_bit, err;

    jseq_ctrl #(.LEN_W(LEN_W), .WAIT_W(WAIT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
        .cmd_len_i(cmd_len), .cmd_wait_i(cmd_wait),
        .take_i(take), .active_i(active), .err_i(err),
        .accept_o(accept), .accept_dr_o(accept_dr),
        .req_o(req), .req_tms_o(req_tms), .req_shift_o(req_shift),
        .req_cap_o(req_cap), .busy_o(busy), .done_o(done),
        .mismatch_o(mismatch)
    );

    jseq_tck_gen #(.DIV_W(DIV_W)) u_tck (
        .clk(clk), .rst_n(rst_n), .half_i(tck_half),
        .req_i(req), .req_tms_i(req_tms),
        .req_tdi_i(req_shift & out_bit), .req_cap_i(req_cap),
        .take_o(take), .sample_o(sample), .sample_cap_o(sample_cap),
        .active_o(active), .tck_o(jtag_tck), .tms_o(jtag_tms),
        .tdi_o(jtag_tdi)
    );

    jseq_scanbuf #(.MAX_LEN(MAX_LEN)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .load_i(accept), .clr_cap_i(accept_dr),
        .data_i(scan_out), .exp_i(scan_expect), .care_i(scan_care),
        .shift_i(take & req_shift), .cap_i(sample_cap), .tdo_i(jtag_tdo),
        .out_bit_o(out_bit), .cap_o(scan_in), .err_o(err)
    );

    // sample is only consumed through sample_cap; keep the rise check honest
    // R2
    sample_only_when_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> !jtag_tck);
endmodule

// File: tb/jtag_cmd_seq_test.sv
module jtag_cmd_seq_test;
    localparam int MAX_LEN = 1024;
    localparam int DIV_W   = 8;
    localparam int WAIT_W  = 16;
    localparam int LEN_W   = 11;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cmd_valid = 1'b0;
    logic [1:0]         cmd_op = 2'b00;
    logic [LEN_W-1:0]   cmd_len = '0;
    logic [WAIT_W-1:0]  cmd_wait = '0;
    logic [DIV_W-1:0]   tck_half = DIV_W'(7);
    logic [MAX_LEN-1:0] scan_out = '0, scan_expect = '0, scan_care = '0;
    logic               jtag_tdo;
    logic               jtag_tck, jtag_tms, jtag_tdi;
    logic [MAX_LEN-1:0] scan_in;
    logic               busy, done, mismatch;

    always #4 clk = ~clk;

    jtag_cmd_seq uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_len(cmd_len), .cmd_wait(cmd_wait), .tck_half(tck_half),
        .scan_out(scan_out), .scan_expect(scan_expect), .scan_care(scan_care),
        .jtag_tdo(jtag_tdo), .jtag_tck(jtag_tck), .jtag_tms(jtag_tms),
        .jtag_tdi(jtag_tdi), .scan_in(scan_in), .busy(busy), .done(done),
        .mismatch(mismatch)
    );

    int tests = 0, fails = 0;
    bit tms_log[$];
    bit tdi_log[$];
    bit exp_tms[$];
    int rise_cnt = 0, hi_run = 0, lo_run = 0, phase_err = 0, done_cnt = 0;
    int cur_half = 7;
    logic tck_prev = 1'b0, tms_hold = 1'b1, tdi_hold = 1'b0;
    logic [MAX_LEN-1:0] resp_v = '0;
    logic [MAX_LEN-1:0] last_cap = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [MAX_LEN-1:0] act, input logic [MAX_LEN-1:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic logic [MAX_LEN-1:0] bitv(input int n);
        logic [MAX_LEN-1:0] v;
        v = '0;
        v[n] = 1'b1;
        return v;
    endfunction

    // per-clock pin monitor: records TMS/TDI at each TCK rise, checks phase
    // lengths and pin stability, and plays the chain's TDO response
    always @(negedge clk) begin
        if (!rst_n) begin
            hi_run = 0; lo_run = 0; tck_prev = 1'b0;
            jtag_tdo = 1'b0;
        end else begin
            if (jtag_tck && !tck_prev) begin
                if (lo_run < cur_half) phase_err++;
                tms_log.push_back(jtag_tms);
                tdi_log.push_back(jtag_tdi);
                rise_cnt++;
                hi_run = 1;
            end else if (!jtag_tck && tck_prev) begin
                if (hi_run != cur_half) phase_err++;
                lo_run = 1;
            end else if (jtag_tck) begin
                hi_run++;
                if (jtag_tms !== tms_hold || jtag_tdi !== tdi_hold) phase_err++;
            end else begin
                lo_run++;
            end
            if (rise_cnt >= 3 && rise_cnt - 3 < MAX_LEN) jtag_tdo = resp_v[rise_cnt-3];
            else jtag_tdo = resp_v[0];
            if (done) done_cnt++;
            tck_prev = jtag_tck; tms_hold = jtag_tms; tdi_hold = jtag_tdi;
        end
    end

    task automatic run_cmd(input logic [1:0] op, input int len, input int wt, input int div,
                           input logic [MAX_LEN-1:0] dv, input logic [MAX_LEN-1:0] ev,
                           input logic [MAX_LEN-1:0] mv, input logic [MAX_LEN-1:0] rv,
                           input string tag, input bit poke);
        logic [MAX_LEN-1:0] lm, exp_cap;
        bit exp_mis, seq_ok, tdi_ok;
        int cyc, d0, busy_err, hdr;
        string rq;
        @(negedge clk);
        tck_half = DIV_W'(div);
        cur_half = (div == 0) ? 1 : div;
        scan_out = dv; scan_expect = ev; scan_care = mv; resp_v = rv;
        cmd_op = op; cmd_len = LEN_W'(len); cmd_wait = WAIT_W'(wt);
        tms_log.delete(); tdi_log.delete(); exp_tms.delete();
        rise_cnt = 0; phase_err = 0;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        d0 = done_cnt;
        chk(busy === 1'b1 || done === 1'b1, "R10", {tag, " busy after accept"}, busy, 1);
        chk(mismatch === 1'b0, "R8", {tag, " mismatch cleared on accept"}, mismatch, 0);
        busy_err = 0; cyc = 0;
        while (done !== 1'b1 && cyc < 60000) begin
            if (poke && cyc == 30) begin cmd_op = 2'b00; cmd_valid = 1'b1; end
            else cmd_valid = 1'b0;
            if (busy !== 1'b1) busy_err++;
            @(negedge clk);
            cyc++;
        end
        cmd_valid = 1'b0;
        chk(cyc < 60000, "R10", {tag, " completes"}, cyc, 0);
        chk(busy_err == 0, "R10", {tag, " busy held until done"}, busy_err, 0);
        chk(busy === 1'b0, "R10", {tag, " busy low with done"}, busy, 0);
        @(negedge clk);
        chk(done === 1'b0, "R10", {tag, " done one cycle"}, done, 0);
        chk(done_cnt - d0 == 1, "R10", {tag, " exactly one done"}, done_cnt - d0, 1);
        for (int i = 0; i < MAX_LEN; i++) lm[i] = (i < len);
        case (op)
            2'b00: begin rq = "R3"; hdr = 0;
                for (int i = 0; i < 5; i++) exp_tms.push_back(1'b1);
                exp_tms.push_back(1'b0); end
            2'b01: begin rq = "R4"; hdr = 4;
                exp_tms.push_back(1); exp_tms.push_back(1);
                exp_tms.push_back(0); exp_tms.push_back(0); end
            2'b10: begin rq = "R5"; hdr = 3;
                exp_tms.push_back(1); exp_tms.push_back(0); exp_tms.push_back(0); end
            default: begin rq = "R9"; hdr = 0;
                for (int i = 0; i < wt; i++) exp_tms.push_back(1'b0); end
        endcase
        if (op == 2'b01 || op == 2'b10) begin
            for (int i = 0; i < len; i++) exp_tms.push_back(i == len - 1);
            exp_tms.push_back(1); exp_tms.push_back(0);
        end
        seq_ok = (tms_log.size() == exp_tms.size());
        if (seq_ok) foreach (exp_tms[i]) if (tms_log[i] != exp_tms[i]) seq_ok = 0;
        chk(seq_ok, rq, {tag, " TMS sequence (pulse count)"}, tms_log.size(), exp_tms.size());
        chk(phase_err == 0, "R2", {tag, " TCK phase length / pin stability"}, phase_err, 0);
        if (op == 2'b01 || op == 2'b10) begin
            tdi_ok = (tdi_log.size() >= hdr + len);
            if (tdi_ok) for (int i = 0; i < len; i++) if (tdi_log[hdr+i] != dv[i]) tdi_ok = 0;
            chk(tdi_ok, rq, {tag, " TDI bits LSB first"}, tdi_ok, 1);
        end
        if (op == 2'b10) begin
            exp_cap = rv & lm;
            exp_mis = |((rv ^ ev) & mv & lm);
            chk(scan_in == exp_cap, "R6", {tag, " captured TDO"}, scan_in, exp_cap);
            chk(mismatch == exp_mis, "R7", {tag, " masked compare"}, mismatch, exp_mis);
        end else begin
            chk(scan_in == last_cap, op == 2'b01 ? "R4" : "R6",
                {tag, " capture untouched"}, scan_in, last_cap);
            chk(mismatch == 1'b0, "R8", {tag, " no mismatch outside DR"}, mismatch, 0);
        end
        last_cap = scan_in;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [MAX_LEN-1:0] pa, pb, pc, ones;
        pa = {32{32'hA5C3_0F96}};
        pb = {32{32'h3C69_D214}};
        pc = {32{32'h0FF0_9A5B}};
        ones = '1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(jtag_tck === 1'b0, "R1", "reset TCK", jtag_tck, 0);
        chk(jtag_tms === 1'b1, "R1", "reset TMS", jtag_tms, 1);
        chk(busy === 1'b0 && done === 1'b0, "R1", "reset busy/done", {busy, done}, 0);
        chk(mismatch === 1'b0, "R1", "reset mismatch", mismatch, 0);
        chk(scan_in === '0, "R1", "reset capture", scan_in, 0);

        run_cmd(2'b00, 0, 0, 7, '0, '0, '0, '0, "R3 reset", 0);
        run_cmd(2'b01, 8, 0, 7, pa, '0, '0, pb, "R4 irscan", 0);
        run_cmd(2'b10, 16, 0, 7, pb, pc, ones, pc, "R5 drscan match", 0);
        run_cmd(2'b01, 10, 0, 5, pc, '0, '0, pa, "R4 irscan keeps capture", 0);
        run_cmd(2'b10, 16, 0, 7, pa, pb ^ bitv(5), ones, pb, "R7 R10 drscan miss poked", 1);
        repeat (12) @(negedge clk);
        chk(mismatch === 1'b1, "R8", "mismatch sticky while idle", mismatch, 1);
        run_cmd(2'b11, 0, 5, 7, '0, '0, '0, '0, "R9 wait 5", 0);
        run_cmd(2'b10, 12, 0, 4, pc, pa ^ bitv(3), ~bitv(3), pa, "R7 uncared bit", 0);
        run_cmd(2'b11, 0, 0, 7, '0, '0, '0, '0, "R9 wait 0", 0);
        run_cmd(2'b10, 8, 0, 7, pb, pc ^ bitv(10), ones, pc, "R7 beyond length", 0);
        run_cmd(2'b10, 1, 0, 0, pa, ~pb, ones, pb, "R11 R2 len1 half0", 0);
        run_cmd(2'b10, 1024, 0, 2, pc, pa ^ bitv(1023), ones, pa, "R11 full length", 0);
        run_cmd(2'b10, 1024, 0, 1, pb, pb, ones, pb, "R11 full length match", 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule